// File: doc/BRIEF.md
# LPC I/O Cycle Target

This block sits on the target side of a Low Pin Count bus and answers I/O read and I/O write cycles that a host starts. It watches the 4-bit multiplexed bus and the active-low frame line on every rising edge of the bus clock. It recognises a start nibble, decodes the cycle type, and shifts in a 16-bit I/O address one nibble per clock. For a write it takes two data nibbles from the host. For a read it returns a byte that the back-end supplies. It drives the sync nibble and the final turnaround itself, and it leaves the bus alone in every other clock.

The bus pins are split into an input nibble, an output nibble and an output enable, so the pad ring can build the tri-state pin. The back-end sees the collected address, an address-hit input that decides whether the target claims the cycle, a one-clock read strobe during which it must present read data, and a one-clock write strobe with the assembled write byte. A visible state code and a ready flag show where the target is in the cycle.

Top module: `lpc_io_target`

## Requirements
- R1: While `lresetN` is low the block is idle at once: `ready`=1, `stateCode`=0, `ladOe`=0, both status strobes low. After reset `ioAddr` and `wrData` read zero.
- R2: A clock with `lframeN`=0 and `ladIn`=4'b0000 is a start, and `ready` falls in the next clock. A clock with `lframeN`=0 and any other nibble while idle leaves the block idle.
- R3: In the clock after a start, `ladIn[3:1]`=3'b000 selects an I/O read and 3'b001 an I/O write. Any other value returns the block to idle in the next clock, with nothing driven.
- R4: The next four clocks carry the address, most significant nibble first. The full 16-bit value is on `ioAddr` from the clock that follows the fourth nibble.
- R5: `addrHit` is sampled in the clock after the fourth address nibble. If it is low, the block drives nothing, raises no status strobe, leaves `wrData` unchanged and is idle in the next clock.
- R6: In a claimed read, the block drives 4'b0000 (sync, ready with no wait) in the third clock after the fourth address nibble. In the two clocks that follow it drives the low nibble and then the high nibble of the `rdData` value sampled during the sync clock.
- R7: `ioRdStatus` is high for exactly the sync clock of a claimed read.
- R8: In a claimed write, the two clocks after the address carry write data with the low nibble first. `wrData` holds the byte, and the block drives 4'b0000 sync in the fifth clock after the fourth address nibble.
- R9: `ioWrStatus` pulses high for one clock, in the clock right after the write sync, while `wrData` holds the written byte.
- R10: After the last read data nibble or the write sync, the block drives 4'b1111 for one clock and then releases the bus. It is idle, with `ready`=1, in the clock after that.
- R11: Whenever `lframeN` is low, the nibble decides the next state: 4'b0000 restarts the cycle, so the next clock again expects the cycle type. Any other nibble abandons the cycle to idle. A start held over several clocks therefore takes effect from its last clock.
- R12: `ladOe` is high only in sync, read-data and first final-turnaround clocks. It is never high while `ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lclk | input | 1 | Bus clock |
| lresetN | input | 1 | Active-low asynchronous reset |
| lframeN | input | 1 | Active-low frame marker |
| ladIn | input | 4 | Nibble sampled from the bus |
| ladOut | output | 4 | Nibble driven onto the bus |
| ladOe | output | 1 | Output enable for `ladOut` |
| addrHit | input | 1 | Back-end claims the collected address |
| rdData | input | 8 | Read byte from the back-end |
| ioAddr | output | 16 | Collected I/O address |
| wrData | output | 8 | Assembled write byte |
| ioRdStatus | output | 1 | One-clock read strobe (sync clock) |
| ioWrStatus | output | 1 | One-clock write strobe (after sync) |
| ready | output | 1 | High while idle and able to accept a start |
| stateCode | output | 5 | Current state code, 0 = idle |

## Verification
Every result is due a fixed number of clocks after the start nibble. The state and all bus-side outputs follow one register stage behind the input nibble. The address is complete one clock after its fourth nibble. The read sync lands three clocks later and the write sync five clocks later, and the write strobe comes one clock after the write sync. The bench drives one nibble per clock just after the rising edge. It then compares every output against the value the requirements give for that exact clock. No check has to wait for an event, so an early or late result is always caught. Restart and abort runs shift the same schedule by the number of extra frame clocks, and the expected values are shifted with it.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;

  localparam int NIB_W     = 4;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 8;
  localparam int ADDR_NIBS = ADDR_W / NIB_W;
  localparam int DATA_NIBS = DATA_W / NIB_W;
  localparam int STATE_W   = 5;

  // cycle-type field lives in bits [3:1] of the nibble after start
  localparam logic [2:0] CT_IO_READ  = 3'b000;
  localparam logic [2:0] CT_IO_WRITE = 3'b001;

  localparam logic [NIB_W-1:0] NIB_START = 4'b0000;
  localparam logic [NIB_W-1:0] NIB_SYNC  = 4'b0000;
  localparam logic [NIB_W-1:0] NIB_ONES  = 4'b1111;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 5'd0,
    ST_CTYPE,
    ST_RD_A1, ST_RD_A2, ST_RD_A3, ST_RD_A4,
    ST_RD_TAR1, ST_RD_TAR2, ST_RD_SYNC,
    ST_RD_D1, ST_RD_D2,
    ST_WR_A1, ST_WR_A2, ST_WR_A3, ST_WR_A4,
    ST_WR_D1, ST_WR_D2,
    ST_WR_TAR1, ST_WR_TAR2, ST_WR_SYNC,
    ST_FTAR1, ST_FTAR2
  } tgtState_e;

  typedef struct packed {
    logic addrShift;
    logic wrShift;
    logic rdCapture;
    logic wrDone;
    logic driveSync;
    logic driveData;
    logic dataNib;
    logic driveOnes;
  } tgtStrobe_t;

endpackage

// File: rtl/lpc_tgt_ctrl.sv
module lpc_tgt_ctrl
  import lpc_tgt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameN,
  input  logic [NIB_W-1:0] ladIn,
  input  logic             addrHit,
  output tgtState_e        state,
  output tgtStrobe_t       strb,
  output logic             ready,
  output logic             rdStatus
);

  tgtState_e nextState;
  logic      inAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:    nextState = ST_IDLE;
      ST_CTYPE: begin
        if (ladIn[3:1] == CT_IO_READ)       nextState = ST_RD_A1;
        else if (ladIn[3:1] == CT_IO_WRITE) nextState = ST_WR_A1;
        else                                nextState = ST_IDLE;
      end
      ST_RD_A1:   nextState = ST_RD_A2;
      ST_RD_A2:   nextState = ST_RD_A3;
      ST_RD_A3:   nextState = ST_RD_A4;
      ST_RD_A4:   nextState = ST_RD_TAR1;
      ST_RD_TAR1: nextState = addrHit ? ST_RD_TAR2 : ST_IDLE;
      ST_RD_TAR2: nextState = ST_RD_SYNC;
      ST_RD_SYNC: nextState = ST_RD_D1;
      ST_RD_D1:   nextState = ST_RD_D2;
      ST_RD_D2:   nextState = ST_FTAR1;
      ST_WR_A1:   nextState = ST_WR_A2;
      ST_WR_A2:   nextState = ST_WR_A3;
      ST_WR_A3:   nextState = ST_WR_A4;
      ST_WR_A4:   nextState = ST_WR_D1;
      ST_WR_D1:   nextState = addrHit ? ST_WR_D2 : ST_IDLE;
      ST_WR_D2:   nextState = ST_WR_TAR1;
      ST_WR_TAR1: nextState = ST_WR_TAR2;
      ST_WR_TAR2: nextState = ST_WR_SYNC;
      ST_WR_SYNC: nextState = ST_FTAR1;
      ST_FTAR1:   nextState = ST_FTAR2;
      ST_FTAR2:   nextState = ST_IDLE;
      default:    nextState = ST_IDLE;
    endcase
    // a low frame line overrides everything: restart or abandon
    if (!frameN) nextState = (ladIn == NIB_START) ? ST_CTYPE : ST_IDLE;
  end

  always_comb begin
    inAddr = (state == ST_RD_A1) || (state == ST_RD_A2) ||
             (state == ST_RD_A3) || (state == ST_RD_A4) ||
             (state == ST_WR_A1) || (state == ST_WR_A2) ||
             (state == ST_WR_A3) || (state == ST_WR_A4);
    strb.addrShift = inAddr && frameN;
    strb.wrShift   = frameN && (((state == ST_WR_D1) && addrHit) ||
                                (state == ST_WR_D2));
    strb.rdCapture = (state == ST_RD_SYNC);
    strb.wrDone    = (state == ST_WR_SYNC) && frameN;
    strb.driveSync = (state == ST_RD_SYNC) || (state == ST_WR_SYNC);
    strb.driveData = (state == ST_RD_D1) || (state == ST_RD_D2);
    strb.dataNib   = (state == ST_RD_D2);
    strb.driveOnes = (state == ST_FTAR1);
  end

  assign ready    = (state == ST_IDLE);
  assign rdStatus = (state == ST_RD_SYNC);

endmodule

// File: rtl/lpc_tgt_datapath.sv
module lpc_tgt_datapath
  import lpc_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NIB_W-1:0]  ladIn,
  input  logic [DATA_W-1:0] rdData,
  input  tgtStrobe_t        strb,
  output logic [ADDR_W-1:0] addrQ,
  output logic [DATA_W-1:0] wrQ,
  output logic [NIB_W-1:0]  ladOut,
  output logic              ladOe,
  output logic              wrPulse
);

  logic [DATA_W-1:0] rdQ;
  logic [NIB_W-1:0]  rdNib [DATA_NIBS];
  logic [ADDR_W-1:0] addrNext;
  logic [DATA_W-1:0] wrNext;

  // address enters at the bottom so the first nibble ends up on top
  generate
    if (ADDR_NIBS > 1) begin : g_addrWide
      assign addrNext = {addrQ[ADDR_W-NIB_W-1:0], ladIn};
    end else begin : g_addrNarrow
      assign addrNext = ladIn;
    end
  endgenerate

  // write data enters at the top so the first nibble ends up at the bottom
  generate
    if (DATA_NIBS > 1) begin : g_wrWide
      assign wrNext = {ladIn, wrQ[DATA_W-1:NIB_W]};
    end else begin : g_wrNarrow
      assign wrNext = ladIn;
    end
  endgenerate

  generate
    for (genvar n = 0; n < DATA_NIBS; n++) begin : g_rdNib
      assign rdNib[n] = rdQ[n*NIB_W +: NIB_W];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      wrQ     <= '0;
      rdQ     <= '0;
      wrPulse <= 1'b0;
    end else begin
      if (strb.addrShift) addrQ <= addrNext;
      if (strb.wrShift)   wrQ   <= wrNext;
      if (strb.rdCapture) rdQ   <= rdData;
      wrPulse <= strb.wrDone;
    end
  end

  always_comb begin
    ladOut = NIB_ONES;
    if (strb.driveSync)      ladOut = NIB_SYNC;
    else if (strb.driveData) ladOut = rdNib[strb.dataNib];
    else if (strb.driveOnes) ladOut = NIB_ONES;
    ladOe = strb.driveSync | strb.driveData | strb.driveOnes;
  end

endmodule

// File: rtl/lpc_io_target.sv
module lpc_io_target
  import lpc_tgt_pkg::*;
(
  input  logic              lclk,
  input  logic              lresetN,
  input  logic              lframeN,
  input  logic [NIB_W-1:0]  ladIn,
  output logic [NIB_W-1:0]  ladOut,
  output logic              ladOe,
  input  logic              addrHit,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] ioAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              ioRdStatus,
  output logic              ioWrStatus,
  output logic              ready,
  output logic [STATE_W-1:0] stateCode
);

  tgtState_e  curState;
  tgtStrobe_t strb;

  lpc_tgt_ctrl i_ctrl (
    .clk      (lclk),
    .rstN     (lresetN),
    .frameN   (lframeN),
    .ladIn    (ladIn),
    .addrHit  (addrHit),
    .state    (curState),
    .strb     (strb),
    .ready    (ready),
    .rdStatus (ioRdStatus)
  );

  lpc_tgt_datapath i_dp (
    .clk     (lclk),
    .rstN    (lresetN),
    .ladIn   (ladIn),
    .rdData  (rdData),
    .strb    (strb),
    .addrQ   (ioAddr),
    .wrQ     (wrData),
    .ladOut  (ladOut),
    .ladOe   (ladOe),
    .wrPulse (ioWrStatus)
  );

  assign stateCode = curState;

endmodule

// File: rtl/lpc_io_target_chk.sv
module lpc_io_target_chk (
  input logic       lclk,
  input logic       lresetN,
  input logic       lframeN,
  input logic [3:0] ladIn,
  input logic [3:0] ladOut,
  input logic       ladOe,
  input logic [7:0] rdData,
  input logic       ioRdStatus,
  input logic       ioWrStatus,
  input logic       ready
);

  a_r12_no_drive_idle: assert property (@(posedge lclk) disable iff (!lresetN)
    ladOe |-> !ready);

  a_r6_sync_zero: assert property (@(posedge lclk) disable iff (!lresetN)
    ioRdStatus |-> (ladOe && ladOut == 4'h0));

  a_r6_low_nibble_next: assert property (@(posedge lclk) disable iff (!lresetN)
    (ioRdStatus && lframeN) |=> (ladOe && ladOut == $past(rdData[3:0])));

  a_r9_single_pulse: assert property (@(posedge lclk) disable iff (!lresetN)
    ioWrStatus |=> !ioWrStatus);

  a_r9_after_sync: assert property (@(posedge lclk) disable iff (!lresetN)
    $rose(ioWrStatus) |-> ($past(ladOe) && $past(ladOut) == 4'h0));

  a_r10_ones_with_wr: assert property (@(posedge lclk) disable iff (!lresetN)
    ioWrStatus |-> (ladOe && ladOut == 4'hF));

  a_r11_restart: assert property (@(posedge lclk) disable iff (!lresetN)
    (!lframeN && ladIn == 4'h0) |=> (!ready && !ladOe));

  a_r2_abort_idle: assert property (@(posedge lclk) disable iff (!lresetN)
    (!lframeN && ladIn != 4'h0) |=> ready);

endmodule

bind lpc_io_target lpc_io_target_chk i_chk (
  .lclk       (lclk),
  .lresetN    (lresetN),
  .lframeN    (lframeN),
  .ladIn      (ladIn),
  .ladOut     (ladOut),
  .ladOe      (ladOe),
  .rdData     (rdData),
  .ioRdStatus (ioRdStatus),
  .ioWrStatus (ioWrStatus),
  .ready      (ready)
);

// File: tb/test_lpc_io_target.sv
`timescale 1ns/1ps
module test_lpc_io_target;

  logic        lclk = 1'b0;
  logic        lresetN = 1'b0;
  logic        lframeN = 1'b1;
  logic [3:0]  ladIn = 4'hF;
  logic [3:0]  ladOut;
  logic        ladOe;
  logic        addrHit = 1'b1;
  logic [7:0]  rdData = 8'h00;
  logic [15:0] ioAddr;
  logic [7:0]  wrData;
  logic        ioRdStatus;
  logic        ioWrStatus;
  logic        ready;
  logic [4:0]  stateCode;

  int total = 0;
  int bad = 0;
  logic [7:0] lastWr = 8'h00;

  lpc_io_target i_lpc_io_target (
    .lclk(lclk), .lresetN(lresetN), .lframeN(lframeN), .ladIn(ladIn),
    .ladOut(ladOut), .ladOe(ladOe), .addrHit(addrHit), .rdData(rdData),
    .ioAddr(ioAddr), .wrData(wrData), .ioRdStatus(ioRdStatus),
    .ioWrStatus(ioWrStatus), .ready(ready), .stateCode(stateCode)
  );

  always #5 lclk = ~lclk;

  task automatic chkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // drive one bus clock, check outputs of the current state, advance
  task automatic step(input logic fr, input logic [3:0] lad, input logic eOe,
                      input logic [3:0] eLad, input logic eRd, input logic eWr,
                      input logic eRdy, input string req);
    lframeN = fr;
    ladIn   = lad;
    #2;
    chkEq(req, {23'd0, ladOe, (ladOe ? ladOut : 4'h0), ioRdStatus, ioWrStatus, ready},
               {23'd0, eOe, (eOe ? eLad : 4'h0), eRd, eWr, eRdy});
    @(posedge lclk); #1;
  endtask

  task automatic doCycle(input bit isWr, input logic [15:0] addr, input logic [7:0] dat,
                         input bit hit, input int extra, input string tag);
    addrHit = hit;
    rdData  = dat;
    step(1'b0, 4'h0, 0, 4'h0, 0, 0, 1, {tag, " R2 start"});
    for (int j = 0; j < extra; j++)
      step(1'b0, 4'h0, 0, 4'h0, 0, 0, 0, {tag, " R11 held start"});
    step(1'b1, isWr ? 4'h2 : 4'h0, 0, 4'h0, 0, 0, 0, {tag, " R3 type"});
    for (int i = 0; i < 4; i++)
      step(1'b1, addr[15-4*i -: 4], 0, 4'h0, 0, 0, 0, {tag, " R4 addr nibble"});
    chkEq({tag, " R4 ioAddr"}, {16'd0, ioAddr}, {16'd0, addr});
    if (!hit) begin
      step(1'b1, isWr ? dat[3:0] : 4'hF, 0, 4'h0, 0, 0, 0, {tag, " R5 miss"});
      for (int k = 0; k < 7; k++)
        step(1'b1, isWr ? dat[7:4] : 4'hF, 0, 4'h0, 0, 0, 1, {tag, " R5 idle after miss"});
      chkEq({tag, " R5 wrData kept"}, {24'd0, wrData}, {24'd0, lastWr});
    end else if (isWr) begin
      step(1'b1, dat[3:0], 0, 4'h0, 0, 0, 0, {tag, " R8 data lo"});
      step(1'b1, dat[7:4], 0, 4'h0, 0, 0, 0, {tag, " R8 data hi"});
      step(1'b1, 4'hF, 0, 4'h0, 0, 0, 0, {tag, " R12 tar"});
      step(1'b1, 4'hF, 0, 4'h0, 0, 0, 0, {tag, " R12 tar"});
      chkEq({tag, " R8 wrData"}, {24'd0, wrData}, {24'd0, dat});
      step(1'b1, 4'hF, 1, 4'h0, 0, 0, 0, {tag, " R8 sync"});
      chkEq({tag, " R9 wrData at strobe"}, {24'd0, wrData}, {24'd0, dat});
      step(1'b1, 4'hF, 1, 4'hF, 0, 1, 0, {tag, " R9 R10 strobe and ones"});
      step(1'b1, 4'hF, 0, 4'h0, 0, 0, 0, {tag, " R10 release"});
      step(1'b1, 4'hF, 0, 4'h0, 0, 0, 1, {tag, " R10 idle"});
      lastWr = dat;
    end else begin
      step(1'b1, 4'hF, 0, 4'h0, 0, 0, 0, {tag, " R12 tar"});
      step(1'b1, 4'hF, 0, 4'h0, 0, 0, 0, {tag, " R12 tar"});
      step(1'b1, 4'hF, 1, 4'h0, 1, 0, 0, {tag, " R6,R7 sync"});
      rdData = ~dat;
      step(1'b1, 4'hF, 1, dat[3:0], 0, 0, 0, {tag, " R6 data lo"});
      step(1'b1, 4'hF, 1, dat[7:4], 0, 0, 0, {tag, " R6 data hi"});
      step(1'b1, 4'hF, 1, 4'hF, 0, 0, 0, {tag, " R10 ones"});
      step(1'b1, 4'hF, 0, 4'h0, 0, 0, 0, {tag, " R10 release"});
      step(1'b1, 4'hF, 0, 4'h0, 0, 0, 1, {tag, " R10 idle"});
    end
  endtask

  task automatic testReset();
    lresetN = 1'b0;
    repeat (3) @(posedge lclk);
    #1;
    lresetN = 1'b1;
    #2;
    chkEq("R1 reset outputs", {ready, ladOe, ioRdStatus, ioWrStatus, stateCode},
                              {1'b1, 1'b0, 1'b0, 1'b0, 5'd0});
    chkEq("R1 reset ioAddr/wrData", {8'd0, ioAddr, wrData}, 32'd0);
    @(posedge lclk); #1;
  endtask

  task automatic testResetMid();
    addrHit = 1'b1;
    step(1'b0, 4'h0, 0, 4'h0, 0, 0, 1, "R2 start");
    step(1'b1, 4'h2, 0, 4'h0, 0, 0, 0, "R3 write type");
    step(1'b1, 4'h1, 0, 4'h0, 0, 0, 0, "R4 addr");
    lresetN = 1'b0;
    #2;
    chkEq("R1 reset mid-cycle", {ready, ladOe, stateCode}, {1'b1, 1'b0, 5'd0});
    @(posedge lclk); #1;
    lresetN = 1'b1;
    lastWr = 8'h00;
    @(posedge lclk); #1;
  endtask

  task automatic testIgnored();
    step(1'b0, 4'h3, 0, 4'h0, 0, 0, 1, "R2 non-start nibble");
    step(1'b1, 4'hF, 0, 4'h0, 0, 0, 1, "R2 still idle");
    step(1'b0, 4'h0, 0, 4'h0, 0, 0, 1, "R2 start");
    step(1'b1, 4'h4, 0, 4'h0, 0, 0, 0, "R3 memory type");
    step(1'b1, 4'hF, 0, 4'h0, 0, 0, 1, "R3 back to idle");
  endtask

  task automatic testAbort();
    step(1'b0, 4'h0, 0, 4'h0, 0, 0, 1, "R2 start");
    step(1'b1, 4'h0, 0, 4'h0, 0, 0, 0, "R3 read type");
    step(1'b1, 4'h9, 0, 4'h0, 0, 0, 0, "R4 addr");
    step(1'b0, 4'h7, 0, 4'h0, 0, 0, 0, "R11 abort nibble");
    step(1'b1, 4'hF, 0, 4'h0, 0, 0, 1, "R11 idle after abort");
  endtask

  initial begin
    repeat (50000) @(posedge lclk);
    bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(posedge lclk); #1;
    testReset();
    doCycle(1'b1, 16'hF0F0, 8'h5A, 1'b1, 0, "wr");
    doCycle(1'b0, 16'hF0F0, 8'hA5, 1'b1, 0, "rd");
    doCycle(1'b0, 16'h1234, 8'h3C, 1'b1, 0, "rd2");
    doCycle(1'b1, 16'hABCD, 8'hC3, 1'b1, 0, "wr2");
    doCycle(1'b0, 16'h0080, 8'h11, 1'b0, 0, "rdMiss");
    doCycle(1'b1, 16'h0081, 8'h77, 1'b0, 0, "wrMiss");
    doCycle(1'b1, 16'h8001, 8'h96, 1'b1, 2, "wrHeld");
    doCycle(1'b0, 16'h7FFE, 8'h69, 1'b1, 1, "rdHeld");
    testIgnored();
    testAbort();
    testResetMid();
    doCycle(1'b0, 16'hFFFF, 8'h0F, 1'b1, 0, "rdAfterReset");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule